// File: doc/BRIEF.md
# PSRAM Configuration and Deep Power-Down Sequencer

This block sits between a local command port and the control pins of a pseudo-static RAM. It runs only configuration traffic: writes to the bus configuration register and the refresh configuration register, reads of either one, and entry to and exit from deep power-down. Configuration cycles are marked by a dedicated control-register-enable pin rather than by a normal memory access. The register value and the register select are both placed on the address lines. The memory clock pin is held low at all times, since every cycle the block issues is asynchronous.

A command is taken when `cmd_valid` and `cmd_ready` are both high. Each access has three parts. A one-cycle setup raises control-register-enable and presents the address. A strobe phase of `HOLD_CYC` cycles then holds chip-select low. Finally chip-select rises and the sequencer returns to idle. A refresh-register write that clears bit 4 arms deep power-down, and the chip-select rise at the end of that write puts the memory to sleep. While asleep, the sequencer accepts only a wake-up. A wake-up drives a single chip-select low pulse to end deep power-down, then waits `RECOV_CYC` cycles before it reports idle again.

Top module: `cfgpd_seq`

## Requirements
- R1: After reset: `status` is 2'b00 (idle), `mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_adv_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_cre` is low, and `cmd_ready` is high.
- R2: A write command (op 1 = bus register, op 2 = refresh register) holds `mem_cs_n` low for exactly `HOLD_CYC` cycles with `mem_cre` high, `mem_we_n` low, `mem_adv_n` low and `mem_oe_n` high. During that time `mem_addr[15:0]` carries the value and `mem_addr[19:18]` carries the select (2'b10 = bus register, 2'b00 = refresh register). The address is stable for as long as chip-select is low.
- R3: A read command (op 3 = bus register, op 4 = refresh register) holds `mem_cs_n` low for `HOLD_CYC` cycles with `mem_cre` high and `mem_oe_n`, `mem_lb_n` and `mem_ub_n` low, and `mem_we_n` high. `mem_dq_in` is sampled in the last strobe cycle. The sampled word appears on `rd_value`, and `rd_done` pulses for one cycle, in the first cycle after the strobe ends.
- R4: `mem_cre` rises and the address is presented one cycle before `mem_cs_n` falls. `mem_cre` returns low in the cycle that `mem_cs_n` rises.
- R5: A refresh-register write with bit 4 of the value at 0 leaves `status` at 2'b10 (powered-down) from the cycle `mem_cs_n` rises. With bit 4 at 1, `status` returns to idle.
- R6: While powered-down, `cmd_ready` is low for every op except wake-up (op 6). Rejected commands cause no pin activity and do not change any register.
- R7: A wake-up while powered-down drives `mem_cs_n` low for one cycle, with `mem_cre` low and `mem_oe_n`/`mem_we_n` high. `status` is then 2'b01 (busy) for `RECOV_CYC` cycles before it returns to idle.
- R8: `mem_clk` is low in every cycle.
- R9: `status` is 2'b01 (busy) throughout every access. `cmd_ready` is low while busy.
- R10: The sleep command (op 5) writes the refresh register with the given value but with bit 4 forced to 0, and so always ends powered-down.
- R11: A wake-up issued while idle is accepted and has no effect: no pin activity, and `status` stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code (1..6 as in the requirements) |
| cmd_data | input | 16 | Register value for write and sleep commands |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| status | output | 2 | 00 idle, 01 busy, 10 powered-down |
| rd_value | output | 16 | Last register word read back |
| rd_done | output | 1 | One-cycle pulse when rd_value is updated |
| mem_clk | output | 1 | Memory clock pin, held low |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_adv_n | output | 1 | Address-valid, active low |
| mem_cre | output | 1 | Control-register-enable, active high |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_addr | output | 22 | Address lines carrying value and register select |
| mem_dq_in | input | 16 | Data bus as seen by the block during reads |

## Verification
The embedded assertions check several properties on every cycle. The address must be stable while chip-select is low. Control-register-enable must lead the chip-select fall. Output-enable and write-enable must never be low together. Chip-select must stay high throughout deep power-down, and a rejected command must not end it. A wake-up pulse must last exactly one cycle. The bench's scenarios cover the rest. A model memory and a scoreboard compare read-back values against what was written. They confirm that the sleep command clears bit 4 and that rejected writes leave the bus register untouched. They also measure the strobe and recovery lengths, and they show that a model device enters and leaves deep power-down on the expected chip-select edges.

// File: rtl/cfgpd_pkg.sv
// Package: shared types for the configuration / deep power-down sequencer.
// Assumes a 16-bit configuration word and a 2-bit register select field.
package cfgpd_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WR_BUS = 3'd1,
        OP_WR_REF = 3'd2,
        OP_RD_BUS = 3'd3,
        OP_RD_REF = 3'd4,
        OP_SLEEP  = 3'd5,
        OP_WAKE   = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_DOWN = 2'b10
    } stat_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_DOWN,
        PH_PULSE,
        PH_RECOV
    } phase_e;

    localparam logic [1:0] SEL_BUS = 2'b10;
    localparam logic [1:0] SEL_REF = 2'b00;
    localparam int         ARM_BIT = 4;

endpackage

// File: rtl/cfgpd_timer.sv
// Module: down-counter used for strobe and recovery windows.
// Assumes load has priority; zero is high whenever the count is zero.
module cfgpd_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load a new window or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cfgpd_fsm.sv
// Module: command sequencer. Accepts local commands and steps through the
// setup, strobe, powered-down, wake pulse and recovery phases.
// Assumes HOLD_CYC and RECOV_CYC are at least 1.
module cfgpd_fsm
    import cfgpd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int HOLD_CYC  = 4,
    parameter int RECOV_CYC = 20,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              timer_zero,
    output logic              cmd_ready,
    output phase_e            phase,
    output logic              is_read,
    output logic [1:0]        sel,
    output logic [DATA_W-1:0] value,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output logic              capture
);
    op_e op;
    logic take;

    assign op = op_e'(cmd_op);

    // Decide whether a command can be taken in the current phase.
    always_comb begin
        case (phase)
            PH_IDLE: cmd_ready = 1'b1;
            PH_DOWN: cmd_ready = (op == OP_WAKE);
            default: cmd_ready = 1'b0;
        endcase
    end

    assign take = cmd_valid && cmd_ready;

    // Load the timer on entry to a timed phase.
    always_comb begin
        timer_load = 1'b0;
        timer_val  = '0;
        if (phase == PH_SETUP) begin
            timer_load = 1'b1;
            timer_val  = CNT_W'(HOLD_CYC - 1);
        end else if (phase == PH_PULSE) begin
            timer_load = 1'b1;
            timer_val  = CNT_W'(RECOV_CYC - 1);
        end
    end

    assign capture = (phase == PH_STROBE) && timer_zero && is_read;

    // Phase register and the latched access descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            is_read <= 1'b0;
            sel     <= SEL_REF;
            value   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (take) begin
                    case (op)
                        OP_WR_BUS: begin phase <= PH_SETUP; is_read <= 1'b0; sel <= SEL_BUS; value <= cmd_data; end
                        OP_WR_REF: begin phase <= PH_SETUP; is_read <= 1'b0; sel <= SEL_REF; value <= cmd_data; end
                        OP_SLEEP: begin
                            phase   <= PH_SETUP;
                            is_read <= 1'b0;
                            sel     <= SEL_REF;
                            value   <= cmd_data & ~(DATA_W'(1) << ARM_BIT);
                        end
                        OP_RD_BUS: begin phase <= PH_SETUP; is_read <= 1'b1; sel <= SEL_BUS; value <= '0; end
                        OP_RD_REF: begin phase <= PH_SETUP; is_read <= 1'b1; sel <= SEL_REF; value <= '0; end
                        default: phase <= PH_IDLE;
                    endcase
                end
                PH_SETUP: phase <= PH_STROBE;
                PH_STROBE: if (timer_zero) begin
                    if (!is_read && sel == SEL_REF && !value[ARM_BIT])
                        phase <= PH_DOWN;
                    else
                        phase <= PH_IDLE;
                end
                PH_DOWN:  if (take) phase <= PH_PULSE;
                PH_PULSE: phase <= PH_RECOV;
                PH_RECOV: if (timer_zero) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // A rejected command in the powered-down phase must not end it.
    AST_DOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DOWN && cmd_valid && op != OP_WAKE) |=> (phase == PH_DOWN)); // R6

    // A wake pulse lasts one cycle and always leads into recovery.
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE) |=> (phase == PH_RECOV)); // R7
endmodule

// File: rtl/cfgpd_pins.sv
// Module: decodes the sequencer phase into memory control pins.
// Assumes the register select sits at SEL_LSB and the value at bit 0.
module cfgpd_pins
    import cfgpd_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int SEL_LSB = 18
) (
    input  phase_e            phase,
    input  logic              is_read,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] value,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              adv_n,
    output logic              cre,
    output logic              lb_n,
    output logic              ub_n,
    output logic [ADDR_W-1:0] addr
);
    logic cfg_phase;
    logic strobe;

    assign cfg_phase = (phase == PH_SETUP) || (phase == PH_STROBE);
    assign strobe    = (phase == PH_STROBE);

    // Drive control pins from the current phase.
    always_comb begin
        cs_n  = !(strobe || phase == PH_PULSE);
        cre   = cfg_phase;
        adv_n = !cfg_phase;
        we_n  = !(strobe && !is_read);
        oe_n  = !(strobe && is_read);
        lb_n  = !(strobe && is_read);
        ub_n  = !(strobe && is_read);
    end

    // Place the value and the register select on the address lines.
    always_comb begin
        addr = '0;
        if (cfg_phase) begin
            addr[DATA_W-1:0]      = value;
            addr[SEL_LSB +: 2]    = sel;
        end
    end
endmodule

// File: rtl/cfgpd_seq.sv
// Module: top of the PSRAM configuration and deep power-down sequencer.
// Assumes mem_dq_in is valid during the last strobe cycle of a read.
module cfgpd_seq
    import cfgpd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int SEL_LSB   = 18,
    parameter int HOLD_CYC  = 4,
    parameter int RECOV_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_ready,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] rd_value,
    output logic              rd_done,
    output logic              mem_clk,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic              mem_cre,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_CYC = (HOLD_CYC > RECOV_CYC) ? HOLD_CYC : RECOV_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e            phase;
    logic              is_read;
    logic [1:0]        sel;
    logic [DATA_W-1:0] value;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              timer_zero;
    logic              capture;

    cfgpd_fsm #(
        .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .timer_zero(timer_zero), .cmd_ready(cmd_ready),
        .phase(phase), .is_read(is_read), .sel(sel), .value(value),
        .timer_load(timer_load), .timer_val(timer_val), .capture(capture)
    );

    cfgpd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val), .zero(timer_zero)
    );

    cfgpd_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_LSB(SEL_LSB)) u_pins (
        .phase(phase), .is_read(is_read), .sel(sel), .value(value),
        .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .adv_n(mem_adv_n),
        .cre(mem_cre), .lb_n(mem_lb_n), .ub_n(mem_ub_n), .addr(mem_addr)
    );

    assign mem_clk = 1'b0;

    // Map the phase onto the reported status code.
    always_comb begin
        case (phase)
            PH_IDLE: status = ST_IDLE;
            PH_DOWN: status = ST_DOWN;
            default: status = ST_BUSY;
        endcase
    end

    // Hold the last word read back and flag its arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_value <= '0;
            rd_done  <= 1'b0;
        end else begin
            rd_done <= capture;
            if (capture)
                rd_value <= mem_dq_in;
        end
    end

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && mem_cre && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R2

    AST_CRE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && mem_cre) |-> $past(mem_cre)); // R4

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3

    AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_DOWN) |-> mem_cs_n); // R6
endmodule

// File: tb/cfgpd_seq_tb.sv
module cfgpd_seq_tb;
    localparam int HOLD  = 4;
    localparam int RECOV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready;
    logic [1:0]  status;
    logic [15:0] rd_value;
    logic        rd_done;
    logic        mem_clk, mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_cre, mem_lb_n, mem_ub_n;
    logic [21:0] mem_addr;
    logic [15:0] mem_dq_in;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    cfgpd_seq #(.HOLD_CYC(HOLD), .RECOV_CYC(RECOV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .status(status), .rd_value(rd_value), .rd_done(rd_done),
        .mem_clk(mem_clk), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_cre(mem_cre), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model memory: configuration registers and a deep power-down flag.
    logic [15:0] m_bus = 16'h9D4F;
    logic [15:0] m_ref = 16'h0010;
    logic        m_down = 1'b0;
    logic        prev_cs_n = 1'b1;
    logic        pend_wr = 1'b0;
    logic [21:0] pend_addr = '0;

    assign mem_dq_in = (!mem_cs_n && mem_cre && !mem_oe_n)
                     ? ((mem_addr[19:18] == 2'b10) ? m_bus : m_ref) : 16'h0000;

    always @(negedge clk) begin
        if (!mem_cs_n && mem_cre && !mem_we_n) begin
            pend_wr   <= 1'b1;
            pend_addr <= mem_addr;
        end
        if (mem_cs_n && !prev_cs_n && pend_wr) begin
            pend_wr <= 1'b0;
            if (pend_addr[19:18] == 2'b10) m_bus <= pend_addr[15:0];
            else begin
                m_ref <= pend_addr[15:0];
                if (!pend_addr[4]) m_down <= 1'b1;
            end
        end
        if (!mem_cs_n && prev_cs_n && m_down) m_down <= 1'b0;
        prev_cs_n <= mem_cs_n;
    end

    // Memory clock must stay low throughout.
    always @(negedge clk) begin
        if (rst_n && mem_clk !== 1'b0) chk(1'b0, "R8", "mem_clk", mem_clk, 0);
    end

    // Scoreboard: expected read words, popped by the monitor on rd_done.
    logic [15:0] exp_q[$];
    logic [15:0] sh_bus = 16'h9D4F;
    logic [15:0] sh_ref = 16'h0010;

    always @(negedge clk) begin
        if (rst_n && rd_done) begin
            if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected rd_done", 1, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rd_value == e, "R3", "read back word", rd_value, e);
            end
        end
    end

    // Drive one command for one cycle; returns ready as seen before the edge.
    task automatic issue(input logic [2:0] op, input logic [15:0] d, output bit rdy);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        #1 rdy = cmd_ready;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
        #1;
    endtask

    // Run a configuration access and check each phase at the pins.
    task automatic access(input logic [2:0] op, input logic [15:0] d, input bit rd,
                          input logic [1:0] s, input logic [15:0] v, input bit to_down,
                          input string req);
        bit rdy;
        bit ok;
        int low;
        issue(op, d, rdy);
        chk(rdy, req, "accepted", rdy, 1);
        // setup cycle
        chk(mem_cre && mem_cs_n && !mem_adv_n && status == 2'b01, "R4", "setup cre before cs",
            {mem_cre, mem_cs_n}, 2'b11);
        ok = 1'b1; low = 0;
        for (int i = 0; i < HOLD + 2; i++) begin
            @(negedge clk); #1;
            if (!mem_cs_n) begin
                low++;
                if (!mem_cre || mem_adv_n || status != 2'b01) ok = 1'b0;
                if (mem_addr[15:0] != v || mem_addr[19:18] != s) ok = 1'b0;
                if (rd && (mem_oe_n || !mem_we_n || mem_lb_n || mem_ub_n)) ok = 1'b0;
                if (!rd && (!mem_oe_n || mem_we_n)) ok = 1'b0;
            end else if (low == HOLD) begin
                if (mem_cre) ok = 1'b0;
                break;
            end
        end
        chk(low == HOLD, req, "strobe length", low, HOLD);
        chk(ok, req, "strobe pins and address", ok, 1);
        chk(status == (to_down ? 2'b10 : 2'b00), "R5", "status after access",
            status, to_down ? 2 : 0);
    endtask

    task automatic do_read(input bit bus);
        exp_q.push_back(bus ? sh_bus : sh_ref);
        access(bus ? 3'd3 : 3'd4, 16'h0, 1'b1, bus ? 2'b10 : 2'b00, 16'h0, 1'b0, "R3");
        @(negedge clk); #1;
    endtask

    task automatic do_wake();
        bit rdy;
        int busy;
        issue(3'd6, 16'h0, rdy);
        chk(rdy, "R7", "wake accepted", rdy, 1);
        chk(!mem_cs_n && !mem_cre && mem_oe_n && mem_we_n, "R7", "wake pulse pins",
            {mem_cs_n, mem_cre}, 0);
        busy = 0;
        for (int i = 0; i < RECOV + 5; i++) begin
            @(negedge clk); #1;
            if (i == 0) chk(mem_cs_n && !m_down, "R7", "pulse one cycle, device awake",
                            {mem_cs_n, m_down}, 2'b10);
            if (status == 2'b01) busy++;
            else break;
        end
        chk(busy == RECOV, "R7", "recovery length", busy, RECOV);
        chk(status == 2'b00, "R7", "idle after recovery", status, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit rdy;
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(status == 2'b00 && cmd_ready, "R1", "reset status/ready", status, 0);
        chk(mem_cs_n && mem_oe_n && mem_we_n && mem_adv_n && !mem_cre && mem_lb_n && mem_ub_n,
            "R1", "reset pins", {mem_cs_n, mem_cre}, 2'b10);
        chk(mem_clk == 1'b0, "R8", "clock pin low", mem_clk, 0);

        // R3 read the initial bus register
        do_read(1'b1);
        // R2 write bus register, read back
        access(3'd1, 16'h8123, 1'b0, 2'b10, 16'h8123, 1'b0, "R2");
        sh_bus = 16'h8123;
        do_read(1'b1);
        // R5 refresh write with arm bit set stays awake
        access(3'd2, 16'h0015, 1'b0, 2'b00, 16'h0015, 1'b0, "R2");
        sh_ref = 16'h0015;
        chk(!m_down, "R5", "no sleep with bit 4 set", m_down, 0);
        do_read(1'b0);

        // R11 wake while idle has no effect
        issue(3'd6, 16'h0, rdy);
        chk(rdy && status == 2'b00 && mem_cs_n, "R11", "idle wake ignored", status, 0);
        @(negedge clk); #1;
        chk(status == 2'b00 && mem_cs_n, "R11", "still idle", status, 0);

        // R10 sleep forces bit 4 clear and powers down
        access(3'd5, 16'h0017, 1'b0, 2'b00, 16'h0007, 1'b1, "R10");
        sh_ref = 16'h0007;
        @(negedge clk); #1;
        chk(m_down && status == 2'b10, "R10", "device asleep", {m_down, status}, 3'b110);

        // R6 rejected commands while asleep
        issue(3'd1, 16'h1111, rdy);
        chk(!rdy, "R6", "write rejected", rdy, 0);
        issue(3'd4, 16'h0, rdy);
        chk(!rdy, "R6", "read rejected", rdy, 0);
        quiet = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            if (!mem_cs_n || mem_cre || status != 2'b10) quiet = 1'b0;
        end
        chk(quiet && m_down, "R6", "no pin activity while asleep", quiet, 1);

        // R7 wake-up
        do_wake();
        do_read(1'b0);
        do_read(1'b1);

        // R5 plain refresh write with bit 4 clear also powers down
        access(3'd2, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b1, "R5");
        sh_ref = 16'h0000;
        // R9 ready low during setup of next access is covered in access; check ready in down
        chk(!cmd_ready, "R9", "not ready for op 0 while down", cmd_ready, 0);
        do_wake();
        do_read(1'b0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule